// File: doc/BRIEF.md
# Configuration Space Enumeration Scanner

This block is the host-side engine that finds which functions exist in a hierarchy of configuration-addressable devices. A start pulse and an inclusive bus window are given. The engine then walks each bus in that window, each device number from 0 to 31 and each function number from 0 to 7. For every tuple it issues one read of the identifier dword and waits for the response. The low half of the response is the vendor identifier. The value all-ones in that half means that nothing answers at that tuple.

Each function that answers becomes an entry on a valid/ready output stream. An entry carries the bus, device and function numbers with the vendor and device identifiers. The stream has no FIFO in front of it. An entry that is not yet taken holds the scan still, so a slow consumer slows the walk but loses nothing. When function 0 of a device is absent, the other seven functions of that device are not probed. A one-cycle done pulse closes the walk.

Top module: `cfg_scan_engine`

## Requirements
- R1: After reset `busy_o`, `done_o`, `rd_req_valid_o` and `ent_valid_o` are all low.
- R2: A start pulse while idle with `bus_first_i <= bus_last_i` raises `busy_o` in the next cycle, and the first read request is (bus_first_i, 0, 0). A start pulse while busy is ignored and does not change the window.
- R3: Tuples are requested in ascending order with function innermost, then device, then bus. Every tuple of the window is requested exactly once unless R4 skips it.
- R4: When the response for function 0 carries vendor 16'hFFFF, functions 1 to 7 of that device are not requested. The next request is function 0 of the following device.
- R5: At most one read is outstanding. A raised request holds its tuple stable until `rd_req_ready_i`, and no new request is raised before the response (`rd_rsp_valid_i`) arrives.
- R6: The response word carries the vendor identifier in bits [15:0] and the device identifier in bits [31:16]. A vendor value other than 16'hFFFF produces exactly one entry carrying that tuple and both identifiers. An all-ones vendor produces no entry.
- R7: An entry raised on `ent_valid_o` holds all its fields until `ent_ready_i` is high at a clock edge. While it waits, no read request is raised.
- R8: `done_o` is high for exactly one cycle. That cycle directly follows the edge that completes the last tuple of the window: the all-ones response, or the accepted entry. `busy_o` is low in that cycle.
- R9: A start pulse while idle with `bus_first_i > bus_last_i` issues no read and raises `done_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| bus_first_i | input | BUS_W | First bus of the window, captured at start |
| bus_last_i | input | BUS_W | Last bus of the window (inclusive), captured at start |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_req_valid_o | output | 1 | Identifier read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_bus_o | output | BUS_W | Bus number of the request |
| rd_req_dev_o | output | DEV_W | Device number of the request |
| rd_req_fn_o | output | FN_W | Function number of the request |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | 2*ID_W | Response: device id high half, vendor id low half |
| ent_valid_o | output | 1 | Discovered entry valid |
| ent_ready_i | input | 1 | Consumer takes the entry |
| ent_bus_o | output | BUS_W | Entry bus number |
| ent_dev_o | output | DEV_W | Entry device number |
| ent_fn_o | output | FN_W | Entry function number |
| ent_vendor_o | output | ID_W | Entry vendor identifier |
| ent_device_o | output | ID_W | Entry device identifier |

## Verification
Some rules are checked by the assertions on every cycle:
- requests and entries stay stable under back-pressure;
- only one read is outstanding, and no request is raised while an entry waits;
- requested tuples rise strictly;
- no entry carries an all-ones vendor;
- done lasts a single cycle and starts correctly for both valid and reversed windows.

Other properties need whole-walk knowledge that only the bench's scenarios can show:
- the exact sequence of tuples, including the function-0 skip;
- the complete list of entries for a known population of devices;
- that a start pulse during a walk changes nothing;
- the exact cycle of done after the final tuple, under random latency, ready stalls and a top-bus window.

// File: rtl/cfgscan_pkg.sv
package cfgscan_pkg;

  // Walk sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_EMIT,
    ST_FIN
  } scan_state_e;

endpackage

// File: rtl/scan_cursor.sv
// Bus/device/function position of the walk, with function-0 skip and end detect.
module scan_cursor #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [BUS_W-1:0] bus_first_i,
  input  logic [BUS_W-1:0] bus_last_i,
  input  logic             step_i,
  input  logic             absent_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [DEV_W-1:0] dev_o,
  output logic [FN_W-1:0]  fn_o,
  output logic             final_o
);

  localparam logic [DEV_W-1:0] DEV_LAST = '1;
  localparam logic [FN_W-1:0]  FN_LAST  = '1;

  logic [BUS_W-1:0] bus_q, stop_q;
  logic [DEV_W-1:0] dev_q;
  logic [FN_W-1:0]  fn_q;
  logic             dev_done, bus_done;

  // the current device is finished after this step
  assign dev_done = (fn_q == FN_LAST) || (absent_i && fn_q == '0);
  assign bus_done = dev_done && (dev_q == DEV_LAST);
  assign final_o  = bus_done && (bus_q == stop_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= '0;
      stop_q <= '0;
      dev_q  <= '0;
      fn_q   <= '0;
    end else if (load_i) begin
      bus_q  <= bus_first_i;
      stop_q <= bus_last_i;
      dev_q  <= '0;
      fn_q   <= '0;
    end else if (step_i) begin
      if (dev_done) begin
        fn_q <= '0;
        if (bus_done) begin
          dev_q <= '0;
          bus_q <= bus_q + 1'b1;
        end else begin
          dev_q <= dev_q + 1'b1;
        end
      end else begin
        fn_q <= fn_q + 1'b1;
      end
    end
  end

  assign bus_o = bus_q;
  assign dev_o = dev_q;
  assign fn_o  = fn_q;

endmodule

// File: rtl/scan_ctrl.sv
// Sequencer: one read at a time, entry hand-off, done pulse.
module scan_ctrl
  import cfgscan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic window_ok_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  input  logic present_i,
  input  logic ent_ready_i,
  input  logic final_i,
  output logic load_o,
  output logic step_o,
  output logic absent_o,
  output logic capture_o,
  output logic req_valid_o,
  output logic ent_valid_o,
  output logic busy_o,
  output logic done_o
);

  scan_state_e state_q, state_d;
  logic        taken;

  assign absent_o  = (state_q == ST_WAIT) && rsp_valid_i && !present_i;
  assign capture_o = (state_q == ST_WAIT) && rsp_valid_i && present_i;
  assign taken     = (state_q == ST_EMIT) && ent_ready_i;
  assign step_o    = absent_o || taken;
  assign load_o    = (state_q == ST_IDLE) && start_i && window_ok_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = window_ok_i ? ST_REQ : ST_FIN;
      ST_REQ:  if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (capture_o)     state_d = ST_EMIT;
        else if (absent_o) state_d = final_i ? ST_FIN : ST_REQ;
      end
      ST_EMIT: if (taken) state_d = final_i ? ST_FIN : ST_REQ;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_valid_o = (state_q == ST_REQ);
  assign ent_valid_o = (state_q == ST_EMIT);
  assign busy_o      = (state_q == ST_REQ) || (state_q == ST_WAIT) || (state_q == ST_EMIT);
  assign done_o      = (state_q == ST_FIN);

endmodule

// File: rtl/scan_entry_reg.sv
// Holds one discovered entry while the output stream is stalled.
module scan_entry_reg #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int ID_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FN_W-1:0]   fn_i,
  input  logic [2*ID_W-1:0] id_word_i,
  output logic [BUS_W-1:0]  bus_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [FN_W-1:0]   fn_o,
  output logic [ID_W-1:0]   vendor_o,
  output logic [ID_W-1:0]   device_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_o    <= '0;
      dev_o    <= '0;
      fn_o     <= '0;
      vendor_o <= '0;
      device_o <= '0;
    end else if (capture_i) begin
      bus_o    <= bus_i;
      dev_o    <= dev_i;
      fn_o     <= fn_i;
      vendor_o <= id_word_i[ID_W-1:0];
      device_o <= id_word_i[2*ID_W-1:ID_W];
    end
  end

endmodule

// File: rtl/cfg_scan_engine.sv
// Top: exhaustive configuration-space walk over a bus window.
module cfg_scan_engine #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int ID_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BUS_W-1:0]  bus_first_i,
  input  logic [BUS_W-1:0]  bus_last_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [BUS_W-1:0]  rd_req_bus_o,
  output logic [DEV_W-1:0]  rd_req_dev_o,
  output logic [FN_W-1:0]   rd_req_fn_o,
  input  logic              rd_rsp_valid_i,
  input  logic [2*ID_W-1:0] rd_rsp_data_i,
  output logic              ent_valid_o,
  input  logic              ent_ready_i,
  output logic [BUS_W-1:0]  ent_bus_o,
  output logic [DEV_W-1:0]  ent_dev_o,
  output logic [FN_W-1:0]   ent_fn_o,
  output logic [ID_W-1:0]   ent_vendor_o,
  output logic [ID_W-1:0]   ent_device_o
);

  localparam logic [ID_W-1:0] NO_VENDOR = '1;

  logic load, step, absent, capture, final_pos, present, window_ok;

  assign present   = rd_rsp_data_i[ID_W-1:0] != NO_VENDOR;
  assign window_ok = bus_first_i <= bus_last_i;

  scan_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .window_ok_i (window_ok),
    .req_ready_i (rd_req_ready_i),
    .rsp_valid_i (rd_rsp_valid_i),
    .present_i   (present),
    .ent_ready_i (ent_ready_i),
    .final_i     (final_pos),
    .load_o      (load),
    .step_o      (step),
    .absent_o    (absent),
    .capture_o   (capture),
    .req_valid_o (rd_req_valid_o),
    .ent_valid_o (ent_valid_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  scan_cursor #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W)) u_cursor (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .bus_first_i (bus_first_i),
    .bus_last_i  (bus_last_i),
    .step_i      (step),
    .absent_i    (absent),
    .bus_o       (rd_req_bus_o),
    .dev_o       (rd_req_dev_o),
    .fn_o        (rd_req_fn_o),
    .final_o     (final_pos)
  );

  scan_entry_reg #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .ID_W(ID_W)) u_entry (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .bus_i     (rd_req_bus_o),
    .dev_i     (rd_req_dev_o),
    .fn_i      (rd_req_fn_o),
    .id_word_i (rd_rsp_data_i),
    .bus_o     (ent_bus_o),
    .dev_o     (ent_dev_o),
    .fn_o      (ent_fn_o),
    .vendor_o  (ent_vendor_o),
    .device_o  (ent_device_o)
  );

endmodule

// File: rtl/scan_chk.sv
// Protocol checker attached to the scanner top.
module scan_chk #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int FN_W  = 3,
  parameter int ID_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [BUS_W-1:0] bus_first_i,
  input logic [BUS_W-1:0] bus_last_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             rd_req_valid_o,
  input logic             rd_req_ready_i,
  input logic [BUS_W-1:0] rd_req_bus_o,
  input logic [DEV_W-1:0] rd_req_dev_o,
  input logic [FN_W-1:0]  rd_req_fn_o,
  input logic             rd_rsp_valid_i,
  input logic             ent_valid_o,
  input logic             ent_ready_i,
  input logic [BUS_W-1:0] ent_bus_o,
  input logic [DEV_W-1:0] ent_dev_o,
  input logic [FN_W-1:0]  ent_fn_o,
  input logic [ID_W-1:0]  ent_vendor_o,
  input logic [ID_W-1:0]  ent_device_o
);

  localparam int KEY_W = BUS_W + DEV_W + FN_W;

  logic [KEY_W-1:0] key, prev_key_q;
  logic             have_prev_q, outst_q;

  assign key = {rd_req_bus_o, rd_req_dev_o, rd_req_fn_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q     <= 1'b0;
      have_prev_q <= 1'b0;
      prev_key_q  <= '0;
    end else begin
      if (rd_req_valid_o && rd_req_ready_i) outst_q <= 1'b1;
      else if (rd_rsp_valid_i)              outst_q <= 1'b0;
      if (done_o) begin
        have_prev_q <= 1'b0;
      end else if (rd_req_valid_o && rd_req_ready_i) begin
        have_prev_q <= 1'b1;
        prev_key_q  <= key;
      end
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(key));

  // R5
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !rd_req_valid_o);

  // R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o && rd_req_ready_i && have_prev_q |-> key > prev_key_q);

  // R7
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid_o && !ent_ready_i |=> ent_valid_o &&
      $stable({ent_bus_o, ent_dev_o, ent_fn_o, ent_vendor_o, ent_device_o}));

  // R7
  entry_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid_o |-> !rd_req_valid_o);

  // R6
  vendor_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid_o |-> ent_vendor_o != '1);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !rd_req_valid_o && !ent_valid_o);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !done_o && start_i && bus_first_i <= bus_last_i |=>
      rd_req_valid_o && rd_req_bus_o == $past(bus_first_i) &&
      rd_req_dev_o == '0 && rd_req_fn_o == '0);

  // R9
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !done_o && start_i && bus_first_i > bus_last_i |=>
      done_o && !rd_req_valid_o);

endmodule

bind cfg_scan_engine scan_chk #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .ID_W(ID_W)) i_scan_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .bus_first_i    (bus_first_i),
  .bus_last_i     (bus_last_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_req_bus_o   (rd_req_bus_o),
  .rd_req_dev_o   (rd_req_dev_o),
  .rd_req_fn_o    (rd_req_fn_o),
  .rd_rsp_valid_i (rd_rsp_valid_i),
  .ent_valid_o    (ent_valid_o),
  .ent_ready_i    (ent_ready_i),
  .ent_bus_o      (ent_bus_o),
  .ent_dev_o      (ent_dev_o),
  .ent_fn_o       (ent_fn_o),
  .ent_vendor_o   (ent_vendor_o),
  .ent_device_o   (ent_device_o)
);

// File: tb/test_cfg_scan_engine.sv
module test_cfg_scan_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  bus_first_i, bus_last_i;
  logic        busy_o, done_o;
  logic        rd_req_valid_o, rd_req_ready_i;
  logic [7:0]  rd_req_bus_o;
  logic [4:0]  rd_req_dev_o;
  logic [2:0]  rd_req_fn_o;
  logic        rd_rsp_valid_i;
  logic [31:0] rd_rsp_data_i;
  logic        ent_valid_o, ent_ready_i;
  logic [7:0]  ent_bus_o;
  logic [4:0]  ent_dev_o;
  logic [2:0]  ent_fn_o;
  logic [15:0] ent_vendor_o, ent_device_o;

  always #5 clk = ~clk;

  cfg_scan_engine i_cfg_scan_engine (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [15:0] exp_req[$];
  logic [47:0] exp_ent[$];

  bit          pending = 0, no_scan = 0, hold_prev = 0;
  int          lat = 0, ev_age = 1000, bp_mode = 0;
  logic [15:0] pend_key;
  logic [48:0] held;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_present(int b, int d, int f);
    if (f == 0) return (d % 4 == 0) || d == 6 || (d == 31 && b % 2 == 0);
    if (d == 3) return 1;              // fn0 absent: must never be probed
    if (d % 8 == 0) return (f % 3 == 1);
    if (d == 6) return f == 7;
    return 0;
  endfunction

  function automatic logic [15:0] vid_of(int b, int d, int f);
    return 16'hA000 | 16'((b & 15) << 8) | 16'(d << 3) | 16'(f);
  endfunction

  function automatic logic [15:0] did_of(int b, int d, int f);
    return {8'(b), 5'(d), 3'(f)};
  endfunction

  task automatic build_expect(input int first, input int last);
    exp_req.delete();
    exp_ent.delete();
    for (int b = first; b <= last; b++)
      for (int d = 0; d < 32; d++)
        for (int f = 0; f < 8; f++) begin
          exp_req.push_back({8'(b), 5'(d), 3'(f)});
          if (is_present(b, d, f))
            exp_ent.push_back({8'(b), 5'(d), 3'(f), vid_of(b, d, f), did_of(b, d, f)});
          else if (f == 0) break;    // R4 skip rule
        end
  endtask

  // Responder / consumer / monitor, all acting on the falling edge
  initial begin
    rd_req_ready_i = 0; rd_rsp_valid_i = 0; rd_rsp_data_i = '0; ent_ready_i = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      ev_age++;
      if (pending && rd_req_valid_o) chk(0, "R5", "request while outstanding", 1, 0);
      if (done_o && !no_scan) chk(ev_age == 1, "R8", "done delay after last tuple", ev_age, 1);
      if (hold_prev)
        chk({ent_valid_o, ent_bus_o, ent_dev_o, ent_fn_o, ent_vendor_o, ent_device_o} == held,
            "R7", "entry held under stall",
            {ent_valid_o, ent_bus_o, ent_dev_o, ent_fn_o, ent_vendor_o, ent_device_o}, held);
      rd_rsp_valid_i = 0;
      if (pending) begin
        if (lat == 0) begin
          int b, d, f;
          b = pend_key[15:8]; d = pend_key[7:3]; f = pend_key[2:0];
          rd_rsp_valid_i = 1;
          rd_rsp_data_i = {did_of(b, d, f), is_present(b, d, f) ? vid_of(b, d, f) : 16'hFFFF};
          if (!is_present(b, d, f)) ev_age = 0;
          pending = 0;
        end else lat--;
      end
      rd_req_ready_i = ($urandom % 4) != 0;
      if (rd_req_valid_o && rd_req_ready_i) begin
        // R2 first request and R3/R4 sequence
        if (exp_req.size() == 0) chk(0, "R3", "unexpected request", {rd_req_bus_o, rd_req_dev_o, rd_req_fn_o}, 0);
        else begin
          logic [15:0] e;
          e = exp_req.pop_front();
          chk({rd_req_bus_o, rd_req_dev_o, rd_req_fn_o} == e, "R3", "request tuple",
              {rd_req_bus_o, rd_req_dev_o, rd_req_fn_o}, e);
        end
        pend_key = {rd_req_bus_o, rd_req_dev_o, rd_req_fn_o};
        pending = 1;
        lat = $urandom % 3;
      end
      ent_ready_i = bp_mode != 0 ? (($urandom % 5) == 0) : (($urandom % 2) == 0);
      if (ent_valid_o && ent_ready_i) begin
        if (exp_ent.size() == 0) chk(0, "R6", "unexpected entry", ent_vendor_o, 0);
        else begin
          logic [47:0] e;
          e = exp_ent.pop_front();
          chk({ent_bus_o, ent_dev_o, ent_fn_o, ent_vendor_o, ent_device_o} == e, "R6", "entry content",
              {ent_bus_o, ent_dev_o, ent_fn_o, ent_vendor_o, ent_device_o}, e);
        end
        ev_age = 0;
      end
      hold_prev = ent_valid_o && !ent_ready_i;
      held = {ent_valid_o, ent_bus_o, ent_dev_o, ent_fn_o, ent_vendor_o, ent_device_o};
    end
  end

  task automatic summary;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wait_done;
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!done_o && guard < 60000);
    chk(done_o, "R8", "done seen", done_o, 1);
    chk(!busy_o, "R8", "busy low with done", busy_o, 0);
    chk(exp_req.size() == 0, "R3", "requests left", exp_req.size(), 0);
    chk(exp_ent.size() == 0, "R6", "entries left", exp_ent.size(), 0);
    @(negedge clk);
    chk(!done_o, "R8", "done one cycle", done_o, 0);
  endtask

  task automatic run_scan(input int first, input int last, input int mode, input bit poke);
    build_expect(first, last);
    bp_mode = mode;
    no_scan = 0;
    bus_first_i = 8'(first);
    bus_last_i  = 8'(last);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o, "R2", "busy after start", busy_o, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      bus_first_i = 8'h00; bus_last_i = 8'h00; start_i = 1;
      @(negedge clk);
      start_i = 0;
      chk(busy_o && !done_o, "R2", "start ignored while busy", {busy_o, done_o}, 2);
    end
    wait_done();
  endtask

  initial begin
    rst_n = 0; start_i = 0; bus_first_i = '0; bus_last_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o, "R1", "busy after reset", busy_o, 0);
    chk(!done_o, "R1", "done after reset", done_o, 0);
    chk(!rd_req_valid_o, "R1", "request after reset", rd_req_valid_o, 0);
    chk(!ent_valid_o, "R1", "entry after reset", ent_valid_o, 0);

    run_scan(8'h10, 8'h11, 0, 1);   // two-bus window, start poked mid-walk
    run_scan(8'hFF, 8'hFF, 1, 0);   // top bus, heavy back-pressure
    run_scan(8'h00, 8'h00, 0, 0);   // bus zero single window

    // R9 reversed window
    no_scan = 1;
    bus_first_i = 8'h22; bus_last_i = 8'h21; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(done_o, "R9", "done after empty window", done_o, 1);
    chk(!busy_o && !rd_req_valid_o, "R9", "no walk for empty window", {busy_o, rd_req_valid_o}, 0);
    repeat (5) begin
      @(negedge clk);
      chk(!rd_req_valid_o && !done_o, "R9", "quiet after empty window", {rd_req_valid_o, done_o}, 0);
    end
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

endmodule